// File: doc/BRIEF.md
# Configuration Stream Capability Registers

This block is a vendor-specific extended capability that sits in the configuration space of a PCIe endpoint. A host uses it to push a core configuration bitstream, one dword at a time, into a downstream configuration engine. The host reads fixed identity registers to find the capability. It sets mode and programming control bits and polls a credit counter. Each credit it sees entitles it to write one 4 KB window of bitstream words into the data register. Accepted words pass through a small in-order FIFO to a valid/ready sink.

A deadline counter starts when a credit is granted. If the window is not completely written before the counter runs out, an error flag is raised. An error reported by the sink also raises the flag. The block records how many words arrived before the error. When fewer than the recovery threshold had arrived, clearing every control bit (a teardown) clears the error. Past the threshold, the error stays latched until reset. When the sink signals the end of the bitstream with no error, the done and success flags are set, and the fabric user-mode flag follows one cycle later.

Accesses are dword-sized, at byte address `regAddr`. The address must have its two low bits at zero. Read data appears one cycle after `regRdEn`, together with `regRdValid`.

Top module: `cfgload_cap`

## Requirements
- R1: Byte 0xB80 reads {NEXT_CAP_OFFSET[11:0], 4'h1, 16'h000B}. Byte 0xB84 reads 32'h05C01172 and byte 0xB88 reads 32'h41721172. The data register at 0xBA8, the reserved offsets (such as 0xB8C, 0xBA4 and 0xBB0) and every offset outside 0xB80..0xBC8 read zero. Read data is valid one cycle after `regRdEn`.
- R2: The dword at 0xB9C carries BOARD_ID in [15:0] and the status field in [31:16], so status bit n sits at dword bit 16+n. Status bit 2 (ready) is mode & begin-request & no error & not done, and it is 0 after reset.
- R3: At 0xBA0, bit 0 (configuration mode) and bit 1 (fabric interface disable) are writable when byte enable 0 is set, and they drive `cfgModeOut` and `fabricDisable`. At 0xBAC, bit 0 (begin request) and bit 1 (transfer start) drive `engineStart` and `xferStart`. All four bits reset to 0, and all other bits of both registers read zero.
- R4: A credit is granted in the cycle after these conditions all hold: mode, begin request and transfer start are set, there is no error and no done, the current window is empty and `sinkReady` is high. Bits [15:8] of 0xBC8 hold the grant total modulo 256, and all other bits read zero.
- R5: A write to 0xBA8 is taken only when all four byte enables are set and the open window still expects words. Any other write at or near the data register delivers nothing to the sink and does not shorten the window.
- R6: Taken words reach the sink in write order. `sinkValid` and `sinkData` hold steady while `sinkReady` is low.
- R7: If a granted window is not filled within DEADLINE_MS (counted in clock cycles of CLK_HZ), status bit 3 (error) is set, ready drops and no further credits are granted.
- R8: An error raised while fewer than RECOVER_BYTES/4 words have been taken in the session is cleared once mode, begin request and transfer start are all zero. After that, a new session grants credits again.
- R9: An error raised after at least RECOVER_BYTES/4 words have been taken stays set through a teardown and through a reopened session, and no credit is granted until reset.
- R10: A high `sinkErr` while there is no error and no done sets status bit 3.
- R11: `sinkEnd` with `sinkErr` low and no error sets status bits 7 (done) and 10 (success). Status bit 5 and `fabricUserMode` rise exactly one cycle later.
- R12: Status bit 4 mirrors the mode bit, and status bit 8 mirrors `fabricClkInUse`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Configuration write strobe |
| regRdEn | input | 1 | Configuration read strobe |
| regAddr | input | 12 | Byte address in configuration space |
| regByteEn | input | 4 | Write byte enables |
| regWrData | input | 32 | Write data |
| regRdValid | output | 1 | Read data valid, one cycle after regRdEn |
| regRdData | output | 32 | Read data |
| sinkValid | output | 1 | Bitstream word available |
| sinkReady | input | 1 | Engine accepts a word / has space for a window |
| sinkData | output | 32 | Bitstream word |
| sinkEnd | input | 1 | Engine saw the end of the bitstream |
| sinkErr | input | 1 | Engine detected a bitstream error |
| fabricClkInUse | input | 1 | Fabric clock selected, shown in status |
| cfgModeOut | output | 1 | Configuration mode bit |
| fabricDisable | output | 1 | Fabric interface disable bit |
| engineStart | output | 1 | Begin request to the engine |
| xferStart | output | 1 | Start-of-transfer flag |
| fabricUserMode | output | 1 | Fabric is in user mode |

## Verification
Several faults show up first at the ports. A window counter that is off by one moves the credit field one word early or late, so a credit read taken after the fifteenth and after the sixteenth word of a window tells the two cases apart. A deadline counter that is off by one, or a recovery threshold on the wrong side, shows up as an error bit that does or does not clear at the next teardown. This is visible one read after the teardown. A FIFO pointer fault produces a sink word that differs from the scoreboard's head on the very handshake where it occurs. A late or early user-mode register moves `fabricUserMode` by one cycle against the done pulse.

// File: rtl/cfgload_pkg.sv
package cfgload_pkg;

  // Dword indices (byte offset >> 2) inside the capability window
  localparam logic [9:0] IDX_CAPHDR    = 10'h2E0;  // 0xB80
  localparam logic [9:0] IDX_VNDHDR    = 10'h2E1;  // 0xB84
  localparam logic [9:0] IDX_MARKER    = 10'h2E2;  // 0xB88
  localparam logic [9:0] IDX_BOARDSTAT = 10'h2E7;  // 0xB9C, status in upper half
  localparam logic [9:0] IDX_MODECTL   = 10'h2E8;  // 0xBA0
  localparam logic [9:0] IDX_DATA      = 10'h2EA;  // 0xBA8
  localparam logic [9:0] IDX_PROGCTL   = 10'h2EB;  // 0xBAC
  localparam logic [9:0] IDX_CREDIT    = 10'h2F2;  // 0xBC8

  // Status field bit positions (host software decodes these)
  localparam int unsigned ST_READY   = 2;
  localparam int unsigned ST_ERROR   = 3;
  localparam int unsigned ST_MODE    = 4;
  localparam int unsigned ST_USER    = 5;
  localparam int unsigned ST_DONE    = 7;
  localparam int unsigned ST_CLKUSE  = 8;
  localparam int unsigned ST_SUCCESS = 10;

  // Strobes from control to datapath
  typedef struct packed {
    logic push;   // take the current write word into the FIFO
    logic flush;  // drop everything queued (session idle)
  } dpStrobe_t;

endpackage

// File: rtl/cfgload_dpath.sv
module cfgload_dpath
  import cfgload_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned DEPTH  = 4   // power of two
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic [DATA_W-1:0] wrData,
  input  logic              sinkReady,
  output logic              sinkValid,
  output logic [DATA_W-1:0] sinkData,
  output logic              fifoFull
);

  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CNT_W = PTR_W + 1;

  logic [DATA_W-1:0] store [DEPTH];
  logic [PTR_W-1:0]  wrPtr, rdPtr;
  logic [CNT_W-1:0]  fill;
  logic              doPush, doPop;

  assign fifoFull  = (fill == CNT_W'(DEPTH));
  assign sinkValid = (fill != '0);
  assign sinkData  = store[rdPtr];
  assign doPush    = strobe.push && !fifoFull;
  assign doPop     = sinkValid && sinkReady;

  // one write-enabled slot per entry
  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (doPush && wrPtr == PTR_W'(g)) store[g] <= wrData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || strobe.flush) begin
      wrPtr <= '0;
      rdPtr <= '0;
      fill  <= '0;
    end else begin
      if (doPush) wrPtr <= wrPtr + PTR_W'(1);
      if (doPop)  rdPtr <= rdPtr + PTR_W'(1);
      if (doPush && !doPop)      fill <= fill + CNT_W'(1);
      else if (doPop && !doPush) fill <= fill - CNT_W'(1);
    end
  end

endmodule

// File: rtl/cfgload_ctrl.sv
module cfgload_ctrl
  import cfgload_pkg::*;
#(
  parameter logic [11:0] NEXT_CAP_OFFSET  = 12'h000,
  parameter logic [15:0] BOARD_ID         = 16'h0000,
  parameter int unsigned WORDS_PER_CREDIT = 1024,
  parameter int unsigned RECOVER_WORDS    = 43008,
  parameter int unsigned DEADLINE_CYCLES  = 5000000
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWrEn,
  input  logic        regRdEn,
  input  logic [11:0] regAddr,
  input  logic [3:0]  regByteEn,
  input  logic [1:0]  ctlWrBits,
  input  logic        fifoFull,
  input  logic        sinkReady,
  input  logic        sinkEnd,
  input  logic        sinkErr,
  input  logic        fabricClkInUse,
  output dpStrobe_t   strobe,
  output logic        regRdValid,
  output logic [31:0] regRdData,
  output logic        cfgModeOut,
  output logic        fabricDisable,
  output logic        engineStart,
  output logic        xferStart,
  output logic        fabricUserMode,
  output logic [15:0] statusVec,
  output logic [7:0]  creditCnt
);

  localparam int unsigned WIN_W = $clog2(WORDS_PER_CREDIT + 1);
  localparam int unsigned TOT_W = $clog2(RECOVER_WORDS + 1);
  localparam int unsigned DL_W  = $clog2(DEADLINE_CYCLES + 1);

  logic [9:0]       wordIdx;
  logic             aligned;
  logic             wrMode, wrProg, wrData;
  logic             modeBit, disBit, engBit, xferBit;
  logic             errFlag, errFatal, doneFlag, userMode;
  logic [WIN_W-1:0] winLeft;
  logic [TOT_W-1:0] wordsIn;
  logic [DL_W-1:0]  deadCnt;
  logic             sessIdle, accept, grant, deadHit, raiseErr, endOk;
  logic [31:0]      rdMux;

  assign wordIdx = regAddr[11:2];
  assign aligned = (regAddr[1:0] == 2'b00);
  assign wrMode  = regWrEn && aligned && wordIdx == IDX_MODECTL && regByteEn[0];
  assign wrProg  = regWrEn && aligned && wordIdx == IDX_PROGCTL && regByteEn[0];
  assign wrData  = regWrEn && aligned && wordIdx == IDX_DATA && regByteEn == 4'hF;

  assign sessIdle = !modeBit && !engBit && !xferBit;
  assign accept   = wrData && winLeft != '0 && !errFlag && !doneFlag
                    && !fifoFull && !sessIdle;
  assign grant    = modeBit && engBit && xferBit && !errFlag && !doneFlag
                    && winLeft == '0 && sinkReady;
  assign deadHit  = winLeft != '0 && deadCnt == DL_W'(DEADLINE_CYCLES - 1);
  assign raiseErr = !errFlag && !doneFlag && (deadHit || sinkErr);
  assign endOk    = sinkEnd && !sinkErr && !errFlag && !doneFlag;

  assign strobe.push  = accept;
  assign strobe.flush = sessIdle;

  // control bits
  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeBit <= 1'b0;
      disBit  <= 1'b0;
      engBit  <= 1'b0;
      xferBit <= 1'b0;
    end else begin
      if (wrMode) begin
        modeBit <= ctlWrBits[0];
        disBit  <= ctlWrBits[1];
      end
      if (wrProg) begin
        engBit  <= ctlWrBits[0];
        xferBit <= ctlWrBits[1];
      end
    end
  end

  // credit window, session word count, deadline
  always_ff @(posedge clk) begin
    if (!rstN) begin
      winLeft   <= '0;
      wordsIn   <= '0;
      deadCnt   <= '0;
      creditCnt <= '0;
    end else begin
      if (grant) creditCnt <= creditCnt + 8'd1;
      if (sessIdle) begin
        winLeft <= '0;
        wordsIn <= '0;
      end else begin
        if (grant)       winLeft <= WIN_W'(WORDS_PER_CREDIT);
        else if (accept) winLeft <= winLeft - WIN_W'(1);
        if (accept && wordsIn < TOT_W'(RECOVER_WORDS)) wordsIn <= wordsIn + TOT_W'(1);
      end
      if (sessIdle || grant || winLeft == '0) deadCnt <= '0;
      else if (!errFlag && !deadHit)          deadCnt <= deadCnt + DL_W'(1);
    end
  end

  // error, done, user mode
  always_ff @(posedge clk) begin
    if (!rstN) begin
      errFlag  <= 1'b0;
      errFatal <= 1'b0;
      doneFlag <= 1'b0;
      userMode <= 1'b0;
    end else begin
      if (raiseErr) begin
        errFlag  <= 1'b1;
        errFatal <= (wordsIn >= TOT_W'(RECOVER_WORDS));
      end else if (errFlag && !errFatal && sessIdle) begin
        errFlag  <= 1'b0;
      end
      if (endOk) doneFlag <= 1'b1;
      userMode <= doneFlag;
    end
  end

  always_comb begin
    statusVec             = '0;
    statusVec[ST_READY]   = modeBit && engBit && !errFlag && !doneFlag;
    statusVec[ST_ERROR]   = errFlag;
    statusVec[ST_MODE]    = modeBit;
    statusVec[ST_USER]    = userMode;
    statusVec[ST_DONE]    = doneFlag;
    statusVec[ST_CLKUSE]  = fabricClkInUse;
    statusVec[ST_SUCCESS] = doneFlag;
  end

  always_comb begin
    rdMux = '0;
    if (aligned) begin
      case (wordIdx)
        IDX_CAPHDR:    rdMux = {NEXT_CAP_OFFSET, 4'h1, 16'h000B};
        IDX_VNDHDR:    rdMux = {12'h05C, 4'h0, 16'h1172};
        IDX_MARKER:    rdMux = 32'h4172_1172;
        IDX_BOARDSTAT: rdMux = {statusVec, BOARD_ID};
        IDX_MODECTL:   rdMux = {30'd0, disBit, modeBit};
        IDX_PROGCTL:   rdMux = {30'd0, xferBit, engBit};
        IDX_CREDIT:    rdMux = {16'd0, creditCnt, 8'd0};
        default:       rdMux = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      regRdValid <= 1'b0;
      regRdData  <= '0;
    end else begin
      regRdValid <= regRdEn;
      if (regRdEn) regRdData <= rdMux;
    end
  end

  assign cfgModeOut     = modeBit;
  assign fabricDisable  = disBit;
  assign engineStart    = engBit;
  assign xferStart      = xferBit;
  assign fabricUserMode = userMode;

endmodule

// File: rtl/cfgload_cap.sv
module cfgload_cap
  import cfgload_pkg::*;
#(
  parameter logic [11:0] NEXT_CAP_OFFSET = 12'h000,
  parameter logic [15:0] BOARD_ID        = 16'h0000,
  parameter int unsigned CREDIT_BYTES    = 4096,
  parameter int unsigned RECOVER_BYTES   = 172032,
  parameter int unsigned CLK_HZ          = 100000000,
  parameter int unsigned DEADLINE_MS     = 50,
  parameter int unsigned FIFO_DEPTH      = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWrEn,
  input  logic        regRdEn,
  input  logic [11:0] regAddr,
  input  logic [3:0]  regByteEn,
  input  logic [31:0] regWrData,
  output logic        regRdValid,
  output logic [31:0] regRdData,
  output logic        sinkValid,
  input  logic        sinkReady,
  output logic [31:0] sinkData,
  input  logic        sinkEnd,
  input  logic        sinkErr,
  input  logic        fabricClkInUse,
  output logic        cfgModeOut,
  output logic        fabricDisable,
  output logic        engineStart,
  output logic        xferStart,
  output logic        fabricUserMode
);

  localparam int unsigned WORDS_PER_CREDIT = CREDIT_BYTES / 4;
  localparam int unsigned RECOVER_WORDS    = RECOVER_BYTES / 4;
  localparam int unsigned DEADLINE_CYCLES  = (CLK_HZ / 1000) * DEADLINE_MS;

  dpStrobe_t   strobe;
  logic        fifoFull;
  logic [15:0] statusVec;
  logic [7:0]  creditCnt;

  cfgload_ctrl #(
    .NEXT_CAP_OFFSET (NEXT_CAP_OFFSET),
    .BOARD_ID        (BOARD_ID),
    .WORDS_PER_CREDIT(WORDS_PER_CREDIT),
    .RECOVER_WORDS   (RECOVER_WORDS),
    .DEADLINE_CYCLES (DEADLINE_CYCLES)
  ) u_ctrl (
    .clk            (clk),
    .rstN           (rstN),
    .regWrEn        (regWrEn),
    .regRdEn        (regRdEn),
    .regAddr        (regAddr),
    .regByteEn      (regByteEn),
    .ctlWrBits      (regWrData[1:0]),
    .fifoFull       (fifoFull),
    .sinkReady      (sinkReady),
    .sinkEnd        (sinkEnd),
    .sinkErr        (sinkErr),
    .fabricClkInUse (fabricClkInUse),
    .strobe         (strobe),
    .regRdValid     (regRdValid),
    .regRdData      (regRdData),
    .cfgModeOut     (cfgModeOut),
    .fabricDisable  (fabricDisable),
    .engineStart    (engineStart),
    .xferStart      (xferStart),
    .fabricUserMode (fabricUserMode),
    .statusVec      (statusVec),
    .creditCnt      (creditCnt)
  );

  cfgload_dpath #(
    .DATA_W(32),
    .DEPTH (FIFO_DEPTH)
  ) u_dpath (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .wrData   (regWrData),
    .sinkReady(sinkReady),
    .sinkValid(sinkValid),
    .sinkData (sinkData),
    .fifoFull (fifoFull)
  );

endmodule

// File: rtl/cfgload_chk.sv
module cfgload_chk (
  input logic        clk,
  input logic        rstN,
  input logic        sinkValid,
  input logic        sinkReady,
  input logic [31:0] sinkData,
  input logic [15:0] statusVec,
  input logic [7:0]  creditCnt,
  input logic        fabricUserMode
);

  // R6: a stalled word is held unchanged
  p_sink_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    sinkValid && !sinkReady |=> sinkValid && $stable(sinkData));

  // R4: credit total only ever steps by one
  p_credit_step_r4: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(creditCnt) |-> creditCnt == $past(creditCnt) + 8'd1);

  // R7: no grant while the error flag is up
  p_no_grant_in_err_r7: assert property (@(posedge clk) disable iff (!rstN)
    statusVec[3] |=> $stable(creditCnt));

  // R11: user mode follows done by one cycle
  p_user_after_done_r11: assert property (@(posedge clk) disable iff (!rstN)
    $rose(statusVec[7]) |=> fabricUserMode);

  // R11: user mode never without done
  p_user_needs_done_r11: assert property (@(posedge clk) disable iff (!rstN)
    fabricUserMode |-> statusVec[7]);

  // R2: ready is never shown together with error
  p_ready_not_err_r2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(statusVec[3]) |-> !statusVec[2]);

endmodule

bind cfgload_cap cfgload_chk chk_i (
  .clk           (clk),
  .rstN          (rstN),
  .sinkValid     (sinkValid),
  .sinkReady     (sinkReady),
  .sinkData      (sinkData),
  .statusVec     (statusVec),
  .creditCnt     (creditCnt),
  .fabricUserMode(fabricUserMode)
);

// File: tb/cfgload_cap_tb_top.sv
module cfgload_cap_tb_top;

  localparam logic [11:0] NEXT_OFF = 12'hC00;
  localparam logic [15:0] BRD      = 16'h00A5;
  localparam int unsigned WPC      = 16;

  localparam logic [11:0] A_CAP = 12'hB80, A_VND = 12'hB84, A_MRK = 12'hB88;
  localparam logic [11:0] A_STAT = 12'hB9C, A_MODE = 12'hBA0, A_DAT = 12'hBA8;
  localparam logic [11:0] A_PROG = 12'hBAC, A_CRD = 12'hBC8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regWrEn = 1'b0, regRdEn = 1'b0;
  logic [11:0] regAddr = '0;
  logic [3:0]  regByteEn = '0;
  logic [31:0] regWrData = '0;
  logic regRdValid;
  logic [31:0] regRdData;
  logic sinkValid;
  logic sinkReady = 1'b1;
  logic [31:0] sinkData;
  logic sinkEnd = 1'b0, sinkErr = 1'b0, fabricClkInUse = 1'b1;
  logic cfgModeOut, fabricDisable, engineStart, xferStart, fabricUserMode;

  int total = 0;
  int bad = 0;
  logic [31:0] expQ[$];

  always #5 clk = ~clk;

  cfgload_cap #(
    .NEXT_CAP_OFFSET(NEXT_OFF), .BOARD_ID(BRD), .CREDIT_BYTES(64),
    .RECOVER_BYTES(192), .CLK_HZ(4000), .DEADLINE_MS(50), .FIFO_DEPTH(4)
  ) dut_i (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d, input logic [3:0] be);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d; regByteEn = be;
    @(negedge clk);
    regWrEn = 1'b0; regByteEn = '0;
  endtask

  task automatic rdChk(input string tag, input logic [11:0] a, input logic [31:0] exp);
    @(negedge clk);
    regRdEn = 1'b1; regAddr = a;
    @(negedge clk);
    regRdEn = 1'b0;
    chk(tag, regRdData, exp);
  endtask

  task automatic sendWord(input logic [31:0] d);
    expQ.push_back(d);
    wr(A_DAT, d, 4'hF);
  endtask

  task automatic sendWindow(input logic [31:0] base);
    for (int i = 0; i < WPC; i++) sendWord(base + i);
  endtask

  task automatic openSess();
    wr(A_MODE, 32'h1, 4'hF);
    wr(A_PROG, 32'h3, 4'hF);
  endtask

  task automatic teardown();
    wr(A_MODE, 32'h0, 4'hF);
    wr(A_PROG, 32'h0, 4'hF);
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic finishRun();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  // scoreboard monitor
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (rstN && sinkValid && sinkReady) begin
        if (expQ.size() == 0) begin
          total++; bad++;
          $display("FAIL R5/R6 unexpected sink word act=%h exp=none", sinkData);
        end else begin
          chk("R6 sink order", sinkData, expQ.pop_front());
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (190000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog act=running exp=finished");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 identity and reserved
    @(negedge clk);
    regRdEn = 1'b1; regAddr = A_CAP;
    @(negedge clk);
    regRdEn = 1'b0;
    chk("R1 read valid", {31'd0, regRdValid}, 32'd1);
    chk("R1 cap header", regRdData, {NEXT_OFF, 4'h1, 16'h000B});
    rdChk("R1 vendor header", A_VND, 32'h05C0_1172);
    rdChk("R1 marker", A_MRK, 32'h4172_1172);
    rdChk("R1 reserved B8C", 12'hB8C, 32'h0);
    rdChk("R1 reserved BA4", 12'hBA4, 32'h0);
    rdChk("R1 reserved BB0", 12'hBB0, 32'h0);
    rdChk("R1 outside window", 12'h040, 32'h0);
    // R2 reset status (clock-in-use input high)
    rdChk("R2 reset status", A_STAT, 32'h0100_00A5);
    rdChk("R4 reset credit", A_CRD, 32'h0);

    // R3 control bits
    wr(A_MODE, 32'hFFFF_FFFF, 4'hF);
    rdChk("R3 mode readback", A_MODE, 32'h3);
    chk("R3 mode outputs", {30'd0, fabricDisable, cfgModeOut}, 32'h3);
    wr(A_MODE, 32'h0, 4'hF);
    wr(A_PROG, 32'hFFFF_FFFF, 4'hF);
    rdChk("R3 prog readback", A_PROG, 32'h3);
    chk("R3 prog outputs", {30'd0, xferStart, engineStart}, 32'h3);
    wr(A_PROG, 32'h0, 4'hF);
    rdChk("R4 no credit when idle", A_CRD, 32'h0);

    // R12 clock mirror, R4 first grant
    fabricClkInUse = 1'b0;
    openSess();
    rdChk("R4 first credit", A_CRD, 32'h0000_0100);
    rdChk("R2 R12 status open", A_STAT, 32'h0014_00A5);

    // R5 ignored writes
    wr(A_DAT, 32'hDEAD_0001, 4'h7);
    wr(12'hBA4, 32'hDEAD_0002, 4'hF);
    @(negedge clk);
    chk("R5 nothing forwarded", {31'd0, sinkValid}, 32'd0);
    rdChk("R1 data reads zero", A_DAT, 32'h0);

    // R6 stall
    sinkReady = 1'b0;
    sendWord(32'h1000_0000);
    sendWord(32'h1000_0001);
    sendWord(32'h1000_0002);
    chk("R6 valid while stalled", {31'd0, sinkValid}, 32'd1);
    chk("R6 head while stalled", sinkData, 32'h1000_0000);
    repeat (3) @(negedge clk);
    chk("R6 head held", sinkData, 32'h1000_0000);
    sinkReady = 1'b1;
    for (int i = 3; i < WPC - 1; i++) sendWord(32'h1000_0000 + i);
    rdChk("R5 window not shortened", A_CRD, 32'h0000_0100);
    sendWord(32'h1000_000F);
    rdChk("R4 second credit", A_CRD, 32'h0000_0200);

    // R7 deadline
    repeat (250) @(negedge clk);
    rdChk("R7 deadline error", A_STAT, 32'h0018_00A5);
    rdChk("R7 no credit after err", A_CRD, 32'h0000_0200);

    // R8 recoverable
    teardown();
    rdChk("R8 error cleared", A_STAT, 32'h0000_00A5);
    openSess();
    rdChk("R8 credits resume", A_CRD, 32'h0000_0300);

    // R10 sink error
    @(negedge clk); sinkErr = 1'b1;
    @(negedge clk); sinkErr = 1'b0;
    rdChk("R10 sink error", A_STAT, 32'h0018_00A5);
    teardown();
    openSess();
    rdChk("R8 reopen after sink error", A_CRD, 32'h0000_0400);

    // R9 fatal past threshold (48 words)
    sendWindow(32'h2000_0000);
    sendWindow(32'h2100_0000);
    sendWindow(32'h2200_0000);
    rdChk("R4 credit after three windows", A_CRD, 32'h0000_0700);
    repeat (250) @(negedge clk);
    teardown();
    rdChk("R9 error stays", A_STAT, 32'h0008_00A5);
    openSess();
    rdChk("R9 no grant after fatal", A_CRD, 32'h0000_0700);

    // R4 wrap after reset
    doReset();
    expQ.delete();
    rdChk("R9 reset clears fatal", A_STAT, 32'h0000_00A5);
    openSess();
    for (int w = 0; w < 255; w++) sendWindow(32'h3000_0000 + (w << 8));
    rdChk("R4 credit wraps to zero", A_CRD, 32'h0);
    sendWindow(32'h4000_0000);
    rdChk("R4 credit after wrap", A_CRD, 32'h0000_0100);

    // R11 done and user mode
    fabricClkInUse = 1'b1;
    @(negedge clk); sinkEnd = 1'b1;
    @(negedge clk); sinkEnd = 1'b0;
    chk("R11 user low in done cycle", {31'd0, fabricUserMode}, 32'd0);
    @(negedge clk);
    chk("R11 user one cycle later", {31'd0, fabricUserMode}, 32'd1);
    rdChk("R11 R12 status done", A_STAT, 32'h05B0_00A5);

    repeat (4) @(negedge clk);
    chk("R6 scoreboard drained", expQ.size(), 32'd0);
    finishRun();
  end

endmodule